// File: doc/BRIEF.md
# Bipolar Zero-Substitution Line Encoder

This block turns a serial binary stream, one bit per clock, into a three-level line code. Every cycle it raises exactly one of three symbol wires: negative, zero or positive. A one goes out as a pulse whose polarity is the opposite of the pulse before it. A zero goes out as the zero symbol. The exception is a stretch of four zeros in a row, which is rewritten so that the line never stays quiet long enough for a receiver to lose its timing.

The rewritten stretch always ends in a violation pulse. This pulse has the same polarity as the pulse before it, so a receiver can recognise it and turn the stretch back into zeros. The encoder counts the pulses sent since the last violation. If that count is odd, the stretch becomes zero, zero, zero, violation. If it is even, the first zero becomes a balancing pulse that follows the normal alternation, and the stretch becomes balance, zero, zero, violation. Either way, successive violations alternate in polarity and the line keeps no DC offset. To rewrite the first zero of a stretch, the encoder must see the three bits that follow it. It therefore holds the stream in a short lookahead pipeline and has a fixed latency of three cycles.

Top module: `zs_line_encoder`

## Requirements
- R1: In every cycle, including during reset, exactly one of `sym_neg_o`, `sym_zero_o`, `sym_pos_o` is high.
- R2: While reset is asserted, and for the first three clock edges after it is released, the zero symbol is driven.
- R3: A bit sampled on clock edge k sets the symbol driven after edge k+3, and no earlier symbol.
- R4: An input one is sent as a pulse of the opposite polarity to the previous nonzero pulse.
- R5: An input zero that is not part of a four-zero stretch is sent as the zero symbol. A stretch of three zeros is sent unchanged.
- R6: Once data leaves the pipeline, the output never shows four consecutive zero symbols.
- R7: When the number of pulses since the last violation is odd, a four-zero stretch is sent as zero, zero, zero, violation. The violation pulse has the same polarity as the previous pulse.
- R8: When that number is even, the stretch is sent as a balancing pulse (opposite to the previous pulse), zero, zero, and a violation of the same polarity as the balancing pulse.
- R9: Balancing and violation pulses both update the remembered polarity. A balancing pulse counts as a pulse, and the count restarts at zero after each violation, so successive violations alternate in polarity.
- R10: After reset the remembered polarity is negative and the pulse count is even. The first pulse is therefore positive, and a stretch of zeros at the very start uses the balancing form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one input bit and one output symbol per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit sampled on each rising edge |
| sym_neg_o | output | 1 | High when the negative symbol is driven |
| sym_zero_o | output | 1 | High when the zero symbol is driven |
| sym_pos_o | output | 1 | High when the positive symbol is driven |

## Verification
A stream of all ones shows plain alternation and a positive first pulse, with no substitution mixed in. A stream of all zeros produces back-to-back balancing stretches, so the parity reset after each violation shows up as alternating violation polarity. A directed mix places stretches after odd and even pulse counts, with three-zero and five- and eight-zero runs. This separates the two substitution forms and shows where a run ends and the next begins. A sparse pseudo-random stream then combines all of these at arbitrary positions, while the latency and fill cycles are checked after every reset.

// File: rtl/zs_pkg.sv
package zs_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_POS  = 2'd1,
        SYM_NEG  = 2'd2
    } sym_e;

    function automatic sym_e pulse_of(input logic positive);
        return positive ? SYM_POS : SYM_NEG;
    endfunction

endpackage

// File: rtl/zs_lookahead_pipe.sv
// Holds the last RUN_LEN-1 input bits so that the decision for the oldest
// bit can see the RUN_LEN-1 bits that follow it (the newest one is live).
module zs_lookahead_pipe #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic head_bit_o,
    output logic head_vld_o,
    output logic run_o
);
    localparam int DEPTH = RUN_LEN - 1;

    typedef struct packed {
        logic [DEPTH-1:0] dat;
        logic [DEPTH-1:0] vld;
    } pipe_t;

    pipe_t p_d, p_q;
    logic [DEPTH-1:0] stage_quiet;

    always_comb begin
        p_d        = p_q;
        p_d.dat[0] = bit_i;
        p_d.vld[0] = 1'b1;
        for (int i = 1; i < DEPTH; i++) begin
            p_d.dat[i] = p_q.dat[i-1];
            p_d.vld[i] = p_q.vld[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // a stage counts toward a run only if it holds a real zero
    for (genvar g = 0; g < DEPTH; g++) begin : g_quiet
        assign stage_quiet[g] = p_q.vld[g] & ~p_q.dat[g];
    end

    assign head_bit_o = p_q.dat[DEPTH-1];
    assign head_vld_o = p_q.vld[DEPTH-1];
    assign run_o      = (&stage_quiet) & ~bit_i;

endmodule

// File: rtl/zs_subst_core.sv
// Polarity memory, pulse-parity tracking and the substitution sequencer.
module zs_subst_core
    import zs_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic head_vld_i,
    input  logic head_bit_i,
    input  logic run_i,
    output sym_e sym_o
);
    localparam int PW = $clog2(RUN_LEN);
    localparam logic [PW-1:0] PH_LOAD = PW'(RUN_LEN - 1);
    localparam logic [PW-1:0] PH_LAST = PW'(1);

    typedef struct packed {
        logic          last_pos;
        logic          odd;
        logic [PW-1:0] phase;
        sym_e          sym;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.sym = SYM_ZERO;
        if (c_q.phase != '0) begin
            // inside a substitution: zeros, then the violation pulse
            c_d.phase = c_q.phase - 1'b1;
            if (c_q.phase == PH_LAST) begin
                c_d.sym = pulse_of(c_q.last_pos);
                c_d.odd = 1'b0;
            end
        end else if (head_vld_i) begin
            if (run_i) begin
                c_d.phase = PH_LOAD;
                if (!c_q.odd) begin
                    c_d.last_pos = ~c_q.last_pos;
                    c_d.sym      = pulse_of(~c_q.last_pos);
                    c_d.odd      = 1'b1;
                end
            end else if (head_bit_i) begin
                c_d.last_pos = ~c_q.last_pos;
                c_d.sym      = pulse_of(~c_q.last_pos);
                c_d.odd      = ~c_q.odd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.last_pos <= 1'b0;
            c_q.odd      <= 1'b0;
            c_q.phase    <= '0;
            c_q.sym      <= SYM_ZERO;
        end else begin
            c_q <= c_d;
        end
    end

    assign sym_o = c_q.sym;

endmodule

// File: rtl/zs_line_drive.sv
module zs_line_drive
    import zs_pkg::*;
(
    input  sym_e sym_i,
    output logic neg_o,
    output logic zero_o,
    output logic pos_o
);
    always_comb begin
        neg_o  = 1'b0;
        zero_o = 1'b0;
        pos_o  = 1'b0;
        case (sym_i)
            SYM_POS: pos_o  = 1'b1;
            SYM_NEG: neg_o  = 1'b1;
            default: zero_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/zs_line_encoder.sv
// RUN_LEN must be 3 or more.
module zs_line_encoder
    import zs_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic sym_neg_o,
    output logic sym_zero_o,
    output logic sym_pos_o
);
    logic head_bit, head_vld, run_zero;
    sym_e sym;

    zs_lookahead_pipe #(.RUN_LEN(RUN_LEN)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_i      (bit_i),
        .head_bit_o (head_bit),
        .head_vld_o (head_vld),
        .run_o      (run_zero)
    );

    zs_subst_core #(.RUN_LEN(RUN_LEN)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_vld_i (head_vld),
        .head_bit_i (head_bit),
        .run_i      (run_zero),
        .sym_o      (sym)
    );

    zs_line_drive u_drive (
        .sym_i  (sym),
        .neg_o  (sym_neg_o),
        .zero_o (sym_zero_o),
        .pos_o  (sym_pos_o)
    );

endmodule

// File: rtl/zs_line_encoder_chk.sv
module zs_line_encoder_chk #(
    parameter int RUN_LEN = 4
) (
    input logic clk,
    input logic rst_n,
    input logic sym_neg_o,
    input logic sym_zero_o,
    input logic sym_pos_o
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] VALID_AT = CW'(RUN_LEN);
    localparam logic [CW-1:0] ZMAX     = CW'(RUN_LEN - 1);

    logic [CW-1:0]        cnt_q, zrun_q;
    logic [RUN_LEN-3:0]   zh_q;
    logic                 prev_pos_q, vpos_q, have_v_q;
    logic                 live, pulse, viol;

    assign live  = (cnt_q == VALID_AT);
    assign pulse = sym_pos_o | sym_neg_o;
    assign viol  = live & pulse & (sym_pos_o == prev_pos_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            zrun_q     <= '0;
            zh_q       <= '0;
            prev_pos_q <= 1'b0;
            vpos_q     <= 1'b0;
            have_v_q   <= 1'b0;
        end else begin
            if (!live) cnt_q <= cnt_q + 1'b1;
            if (live) begin
                zh_q <= {zh_q, sym_zero_o};
                if (!sym_zero_o)       zrun_q <= '0;
                else if (zrun_q != ZMAX) zrun_q <= zrun_q + 1'b1;
                if (pulse) prev_pos_q <= sym_pos_o;
                if (viol) begin
                    vpos_q   <= sym_pos_o;
                    have_v_q <= 1'b1;
                end
            end
        end
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sym_neg_o, sym_zero_o, sym_pos_o}) == 1);

    p_fill_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> sym_zero_o);

    p_no_long_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && zrun_q == ZMAX) |-> !sym_zero_o);

    p_viol_after_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (&zh_q));

    p_viol_alternate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && have_v_q) |-> (sym_pos_o != vpos_q));

endmodule

bind zs_line_encoder zs_line_encoder_chk #(.RUN_LEN(RUN_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_neg_o  (sym_neg_o),
    .sym_zero_o (sym_zero_o),
    .sym_pos_o  (sym_pos_o)
);

// File: tb/sim_zs_line_encoder.sv
`timescale 1ns/1ps
module sim_zs_line_encoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_i = 1'b0;
    logic sym_neg_o, sym_zero_o, sym_pos_o;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int    stim[$];
    int    padded[$];
    int    exp_sym[$];
    string exp_tag[$];

    always #4 clk = ~clk;

    zs_line_encoder u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_i      (bit_i),
        .sym_neg_o  (sym_neg_o),
        .sym_zero_o (sym_zero_o),
        .sym_pos_o  (sym_pos_o)
    );

    task automatic chk(input string tag, input int act, input int expv);
        n_total++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int line_val();
        return sym_pos_o ? 1 : (sym_neg_o ? -1 : 0);
    endfunction

    // behavioural model: scan the bit list with full knowledge of what follows
    task automatic build_model();
        int last = -1;
        int cnt  = 0;
        bit first = 1'b1;
        bit after_sub = 1'b0;
        int i = 0;
        exp_sym.delete();
        exp_tag.delete();
        while (i < padded.size()) begin
            if (i + 3 < padded.size() && padded[i] == 0 && padded[i+1] == 0
                && padded[i+2] == 0 && padded[i+3] == 0) begin
                if (cnt % 2 == 1) begin
                    exp_sym.push_back(0); exp_tag.push_back("R7");
                end else begin
                    last = -last;
                    exp_sym.push_back(last);
                    exp_tag.push_back(first ? "R10" : "R8");
                    first = 1'b0;
                end
                exp_sym.push_back(0);    exp_tag.push_back("R7");
                exp_sym.push_back(0);    exp_tag.push_back("R7");
                exp_sym.push_back(last); exp_tag.push_back("R7");
                cnt = 0;
                after_sub = 1'b1;
                i += 4;
            end else if (padded[i] == 1) begin
                last = -last;
                cnt++;
                exp_sym.push_back(last);
                exp_tag.push_back(first ? "R10" : (after_sub ? "R9" : "R4"));
                first = 1'b0;
                after_sub = 1'b0;
                i++;
            end else begin
                exp_sym.push_back(0); exp_tag.push_back("R5");
                i++;
            end
        end
    endtask

    task automatic run_seq();
        int zrun = 0;
        padded = stim;
        repeat (3) padded.push_back(1);
        build_model();
        rst_n = 1'b0;
        bit_i = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R1", $countones({sym_neg_o, sym_zero_o, sym_pos_o}), 1);
            chk("R2", line_val(), 0);
        end
        rst_n = 1'b1;
        for (int c = 0; c < padded.size(); c++) begin
            bit_i = padded[c][0];
            @(negedge clk);
            chk("R1", $countones({sym_neg_o, sym_zero_o, sym_pos_o}), 1);
            if (c < 3) begin
                chk(c == 2 ? "R3" : "R2", line_val(), 0);
            end else begin
                chk(exp_tag[c-3], line_val(), exp_sym[c-3]);
                if (c == 3) chk("R3", line_val(), exp_sym[0]);
                zrun = (line_val() == 0) ? zrun + 1 : 0;
                n_total++;
                if (zrun >= 4) begin
                    n_fail++;
                    $display("FAIL R6: actual %0d zero symbols in a row expected at most 3", zrun);
                end
            end
        end
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        // all ones: plain alternation, first pulse positive
        stim.delete();
        repeat (12) stim.push_back(1);
        run_seq();
        // all zeros: repeated balancing substitutions
        stim.delete();
        repeat (17) stim.push_back(0);
        run_seq();
        // directed mix of odd and even parity, short and long runs
        stim = '{1, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0,
                 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 1};
        run_seq();
        // sparse pseudo-random stream
        stim.delete();
        for (int k = 0; k < 200; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            stim.push_back((lfsr[0] & lfsr[5]) ? 1 : 0);
        end
        run_seq();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule